// File: doc/BRIEF.md
# Resizable CAM-Tag Cache Sub-Bank

This block is the tag side of one sub-bank in a cache built from many small, fully associative sub-banks. The sub-bank acts as one set, and each of its lines is a way. An access address is split into three fields: a line offset in the low bits, a bank index above it, and the tag in the remaining high bits. Only the sub-bank whose fixed identity matches the bank index takes part in an access. That sub-bank compares the incoming tag against all of its stored tags at once. A match raises the word line of the hitting entry, and the data array that sits beside the block uses it for the read or the write.

The number of powered lines can be changed at run time through a target count. Lines at or above the live count are switched off. They never match a lookup and are never chosen by a fill. Growing the sub-bank takes effect in one step. Shrinking removes one line per cycle, starting from the highest live line. Each removed line is invalidated. If the line was dirty, its line address is first handed out for writeback. Fills use first-in first-out replacement over the live lines. A write hit marks the line dirty. A fill that evicts a dirty line also reports that line for writeback.

Top module: `cam_subbank`

## Requirements
- R1: An access or a fill takes effect only when address bits [9:5] equal the sub-bank's `BANK_ID`. For any other bank, `hit` and `wordline` are 0 and no stored state changes.
- R2: In the same cycle as the request, a lookup compares tag bits [31:10] with every live valid line. On a match it drives `hit`=1 and sets `wordline` bit i, where i is the index of the matching line.
- R3: A line whose index is at or above `active_lines` never hits, and its `wordline` bit stays 0.
- R4: A fill writes the tag into the line chosen by the replacement pointer, marks that line valid and clean, and advances the pointer. The pointer returns to line 0 after line `active_lines`-1. A fill is ignored while `active_lines` is 0.
- R5: A write hit (`req_write`=1) sets the dirty state of the hitting line. A read hit leaves the dirty state unchanged.
- R6: When `active_cnt` is larger than `active_lines`, `active_lines` takes that value on the next clock edge. Values above `LINES` are clamped to `LINES`.
- R7: When `active_cnt` is smaller than `active_lines`, each shrink step removes line `active_lines`-1 and lowers `active_lines` by one. A dirty removed line produces a one-cycle `wb_valid` pulse in the following cycle, with `wb_addr` = {tag, bank, 5'b0}. A clean removed line produces no pulse.
- R8: No shrink step is taken in a cycle that carries a fill or a write access to this sub-bank. The step is postponed to the next free cycle.
- R9: If a shrink step leaves the replacement pointer at or above the new `active_lines`, the pointer returns to line 0.
- R10: A fill that replaces a valid dirty line raises `wb_valid` in the following cycle, with `wb_addr` holding the evicted line's address.
- R11: After reset, `active_lines` is 0, every line is invalid and clean, the pointer is at line 0, and `wb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Request address |
| fill_valid | input | 1 | Fill request |
| fill_addr | input | ADDR_W | Address of the line being filled |
| active_cnt | input | CNT_W | Target number of live lines |
| hit | output | 1 | Lookup matched a live line |
| wordline | output | LINES | One-hot select of the matching line |
| active_lines | output | CNT_W | Current number of live lines |
| wb_valid | output | 1 | Dirty line handed out for writeback |
| wb_addr | output | ADDR_W | Line address of that dirty line |

## Verification
The bench first fills past the live line count, so the replacement pointer has to wrap. A design that wraps at the full line count would fill an unpowered line, and the wordline the bench expects would not appear. Next the bench shrinks across a mix of clean and dirty lines, and it checks the live count and the writeback port after every cycle. A design that removes several lines at once, or that reports clean lines, would break that sequence. The bench then asks for a shrink in the same cycle as a fill. This catches a design that steps regardless of the fill and loses the victim writeback. It also shrinks under a high pointer and checks where the next fill lands. The remaining checks cover accesses to a foreign bank, clamping of the target count, and fills while no line is live. Each of these would show up as a hit or an allocation that should not exist.

// File: rtl/cam_subbank_pkg.sv
package cam_subbank_pkg;
  // Origin of a state update on a line in the current cycle.
  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_FILL   = 2'd1,
    UPD_SHRINK = 2'd2
  } upd_src_e;
endpackage

// File: rtl/cam_lookup.sv
module cam_lookup #(
  parameter int LINES = 32,
  parameter int TAG_W = 22,
  parameter int CNT_W = 6
) (
  input  logic                en,
  input  logic [TAG_W-1:0]    key,
  input  logic [TAG_W-1:0]    tags [LINES],
  input  logic [LINES-1:0]    valid,
  input  logic [CNT_W-1:0]    live_cnt,
  output logic [LINES-1:0]    match
);
  // One comparator per line, all evaluated in parallel.
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    logic powered;
    assign powered  = (CNT_W'(i) < live_cnt);
    assign match[i] = en && powered && valid[i] && (tags[i] == key);
  end
endmodule

// File: rtl/cam_size_ctl.sv
module cam_size_ctl #(
  parameter int LINES = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] target,
  input  logic             stall,
  output logic [CNT_W-1:0] live_q,
  output logic             shrink_fire
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(LINES);

  logic [CNT_W-1:0] tgt_c;
  logic [CNT_W-1:0] live_d;
  logic             live_en;

  always_comb begin
    tgt_c       = (target > MAX_CNT) ? MAX_CNT : target;
    shrink_fire = (tgt_c < live_q) && !stall;
    live_en     = 1'b0;
    live_d      = live_q;
    if (tgt_c > live_q) begin
      live_en = 1'b1;
      live_d  = tgt_c;
    end else if (shrink_fire) begin
      live_en = 1'b1;
      live_d  = live_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (live_en) live_q <= live_d;
  end
endmodule

// File: rtl/cam_fifo_ptr.sv
module cam_fifo_ptr #(
  parameter int LINES = 32,
  parameter int CNT_W = 6,
  parameter int LW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             shrink_fire,
  input  logic [CNT_W-1:0] live_q,
  output logic [LW-1:0]    ptr_q
);
  logic [LW-1:0]    ptr_d;
  logic             ptr_en;
  logic [CNT_W-1:0] ptr_w;
  logic [CNT_W-1:0] nxt_w;

  always_comb begin
    ptr_w  = CNT_W'(ptr_q);
    nxt_w  = ptr_w + CNT_W'(1);
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    if (shrink_fire) begin
      // Live count drops to live_q-1; pointer must stay below it.
      if (ptr_w >= live_q - CNT_W'(1)) begin
        ptr_en = 1'b1;
        ptr_d  = '0;
      end
    end else if (step) begin
      ptr_en = 1'b1;
      ptr_d  = (nxt_w >= live_q) ? '0 : LW'(nxt_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/cam_subbank.sv
module cam_subbank
  import cam_subbank_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 5,
  parameter int IDX_W   = 5,
  parameter int LINES   = 32,
  parameter int BANK_ID = 0,
  localparam int CNT_W  = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [CNT_W-1:0]  active_cnt,
  output logic              hit,
  output logic [LINES-1:0]  wordline,
  output logic [CNT_W-1:0]  active_lines,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [IDX_W-1:0] MY_BANK = IDX_W'(BANK_ID);

  // Line state
  logic [TAG_W-1:0] tag_q [LINES];
  logic [TAG_W-1:0] tag_d [LINES];
  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic             wb_valid_q, wb_valid_d;
  logic [ADDR_W-1:0] wb_addr_q, wb_addr_d;

  // Decode
  logic             req_sel, fill_sel, fill_go, wr_req, wr_hit;
  logic [TAG_W-1:0] req_tag, fill_tag;
  logic [LINES-1:0] match;
  logic [CNT_W-1:0] live_q;
  logic             shrink_fire;
  logic [LW-1:0]    ptr_q;
  logic [LW-1:0]    victim;
  upd_src_e         src;

  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign req_sel  = req_valid  && (req_addr[OFF_W +: IDX_W]  == MY_BANK);
  assign fill_sel = fill_valid && (fill_addr[OFF_W +: IDX_W] == MY_BANK);
  assign fill_go  = fill_sel && (live_q != '0);
  assign wr_req   = req_sel && req_write;

  cam_lookup #(.LINES(LINES), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_lookup (
    .en       (req_sel),
    .key      (req_tag),
    .tags     (tag_q),
    .valid    (valid_q),
    .live_cnt (live_q),
    .match    (match)
  );

  cam_size_ctl #(.LINES(LINES), .CNT_W(CNT_W)) u_size (
    .clk         (clk),
    .rst_n       (rst_n),
    .target      (active_cnt),
    .stall       (fill_go || wr_req),
    .live_q      (live_q),
    .shrink_fire (shrink_fire)
  );

  cam_fifo_ptr #(.LINES(LINES), .CNT_W(CNT_W), .LW(LW)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (fill_go),
    .shrink_fire (shrink_fire),
    .live_q      (live_q),
    .ptr_q       (ptr_q)
  );

  assign wr_hit = wr_req && (|match);

  // Next-state logic
  always_comb begin
    tag_d      = tag_q;
    valid_d    = valid_q;
    dirty_d    = dirty_q;
    wb_valid_d = 1'b0;
    wb_addr_d  = wb_addr_q;

    if (fill_go)          src = UPD_FILL;
    else if (shrink_fire) src = UPD_SHRINK;
    else                  src = UPD_NONE;

    victim = (src == UPD_FILL) ? ptr_q : LW'(live_q - CNT_W'(1));

    if (wr_hit) dirty_d = dirty_q | match;

    if (src != UPD_NONE) begin
      if (valid_q[victim] && dirty_q[victim]) begin
        wb_valid_d = 1'b1;
        wb_addr_d  = {tag_q[victim], MY_BANK, {OFF_W{1'b0}}};
      end
      dirty_d[victim] = 1'b0;
      if (src == UPD_FILL) begin
        tag_d[victim]   = fill_tag;
        valid_d[victim] = 1'b1;
      end else begin
        valid_d[victim] = 1'b0;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      dirty_q    <= '0;
      wb_valid_q <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      dirty_q    <= dirty_d;
      wb_valid_q <= wb_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wb_addr_q <= '0;
    else if (wb_valid_d) wb_addr_q <= wb_addr_d;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          tag_q[i] <= '0;
      else if (fill_go && ptr_q == LW'(i)) tag_q[i] <= tag_d[i];
    end
  end

  assign hit          = |match;
  assign wordline     = match;
  assign active_lines = live_q;
  assign wb_valid     = wb_valid_q;
  assign wb_addr      = wb_addr_q;
endmodule

// File: rtl/cam_subbank_chk.sv
module cam_subbank_chk #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 5,
  parameter int IDX_W   = 5,
  parameter int LINES   = 32,
  parameter int BANK_ID = 0,
  parameter int CNT_W   = 6,
  parameter int LW      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              fill_valid,
  input logic              hit,
  input logic [LINES-1:0]  wordline,
  input logic [CNT_W-1:0]  active_lines,
  input logic              wb_valid,
  input logic [LW-1:0]     ptr
);
  logic [LINES-1:0] live_mask;
  always_comb begin
    for (int i = 0; i < LINES; i++) live_mask[i] = (i < int'(active_lines));
  end

  // R1
  bank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (req_valid && req_addr[OFF_W +: IDX_W] == IDX_W'(BANK_ID)));

  // R3
  off_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wordline & ~live_mask) == '0);

  // R6
  live_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_lines <= CNT_W'(LINES));

  // R7
  shrink_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_lines < $past(active_lines)) |-> (active_lines == $past(active_lines) - CNT_W'(1)));

  // R9
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(ptr) < active_lines) || (ptr == '0));

  // R10
  wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($past(fill_valid) || (active_lines < $past(active_lines))));
endmodule

bind cam_subbank cam_subbank_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LINES(LINES),
  .BANK_ID(BANK_ID), .CNT_W(CNT_W), .LW(LW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .fill_valid   (fill_valid),
  .hit          (hit),
  .wordline     (wordline),
  .active_lines (active_lines),
  .wb_valid     (wb_valid),
  .ptr          (ptr_q)
);

// File: tb/tb_cam_subbank.sv
`timescale 1ns/1ps
module tb_cam_subbank;
  localparam int ADDR_W = 32;
  localparam int LINES  = 32;
  localparam int CNT_W  = 6;
  localparam int BANK   = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write, fill_valid;
  logic [ADDR_W-1:0] req_addr, fill_addr;
  logic [CNT_W-1:0]  active_cnt;
  logic              hit, wb_valid;
  logic [LINES-1:0]  wordline;
  logic [CNT_W-1:0]  active_lines;
  logic [ADDR_W-1:0] wb_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cam_subbank #(.BANK_ID(BANK)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .active_cnt(active_cnt),
    .hit(hit), .wordline(wordline), .active_lines(active_lines),
    .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tg, input int bk);
    return {22'(tg), 5'(bk), 5'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input int tg, input int bk, input bit wr,
                        input bit exp_hit, input logic [LINES-1:0] exp_wl, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = mk(tg, bk);
    #1;
    chk(hit == exp_hit, req, 64'(hit), 64'(exp_hit));
    chk(wordline == exp_wl, req, 64'(wordline), 64'(exp_wl));
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic fill(input int tg, input int bk);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(tg, bk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(active_lines == 0, "R11", 64'(active_lines), 0);
    chk(wb_valid == 1'b0, "R11", 64'(wb_valid), 0);
    access(1, BANK, 0, 0, '0, "R11");
  endtask

  task automatic t_fill_wrap;
    @(negedge clk); active_cnt = 4;
    @(negedge clk);
    chk(active_lines == 4, "R6", 64'(active_lines), 4);
    for (int i = 0; i < 4; i++) fill(16'h100 + i, BANK);          // A..D -> lines 0..3
    for (int i = 0; i < 4; i++) access(16'h100 + i, BANK, 0, 1, LINES'(1) << i, "R2");
    fill(16'h200, BANK);                                          // E wraps to line 0
    access(16'h200, BANK, 0, 1, LINES'(1), "R4");
    access(16'h100, BANK, 0, 0, '0, "R4");
  endtask

  task automatic t_bank;
    access(16'h101, 2, 0, 0, '0, "R1");                            // B tag, wrong bank
    fill(16'h300, 2);                                             // ignored
    access(16'h300, BANK, 0, 0, '0, "R1");
    fill(16'h301, BANK);                                          // G -> line 1
    access(16'h301, BANK, 0, 1, LINES'(2), "R1");
  endtask

  task automatic t_dirty;
    access(16'h102, BANK, 1, 1, LINES'(4), "R5");                 // C dirty
    fill(16'h400, BANK);                                          // H replaces C
    chk(wb_valid == 1'b1, "R10", 64'(wb_valid), 1);
    chk(wb_addr == mk(16'h102, BANK), "R10", 64'(wb_addr), 64'(mk(16'h102, BANK)));
    access(16'h103, BANK, 0, 1, LINES'(8), "R5");                 // read D
    fill(16'h401, BANK);                                          // I replaces D clean
    chk(wb_valid == 1'b0, "R5", 64'(wb_valid), 0);
  endtask

  task automatic t_shrink;
    access(16'h400, BANK, 1, 1, LINES'(4), "R5");                 // H dirty
    access(16'h301, BANK, 1, 1, LINES'(2), "R5");                 // G dirty
    active_cnt = 1;
    @(negedge clk);
    chk(active_lines == 3, "R7", 64'(active_lines), 3);
    chk(wb_valid == 1'b0, "R7", 64'(wb_valid), 0);
    @(negedge clk);
    chk(active_lines == 2, "R7", 64'(active_lines), 2);
    chk(wb_valid == 1'b1 && wb_addr == mk(16'h400, BANK), "R7", 64'(wb_addr), 64'(mk(16'h400, BANK)));
    @(negedge clk);
    chk(active_lines == 1, "R7", 64'(active_lines), 1);
    chk(wb_valid == 1'b1 && wb_addr == mk(16'h301, BANK), "R7", 64'(wb_addr), 64'(mk(16'h301, BANK)));
    @(negedge clk);
    chk(active_lines == 1 && wb_valid == 1'b0, "R7", 64'(wb_valid), 0);
    access(16'h401, BANK, 0, 0, '0, "R3");
    access(16'h200, BANK, 0, 1, LINES'(1), "R3");
  endtask

  task automatic t_ptr_reset;
    active_cnt = 4;
    @(negedge clk);
    chk(active_lines == 4, "R6", 64'(active_lines), 4);
    fill(16'h500, BANK); fill(16'h501, BANK); fill(16'h502, BANK);   // J,K,L -> 0,1,2
    active_cnt = 2;
    repeat (2) @(negedge clk);
    chk(active_lines == 2, "R9", 64'(active_lines), 2);
    fill(16'h503, BANK);                                             // M -> line 0
    access(16'h503, BANK, 0, 1, LINES'(1), "R9");
    access(16'h500, BANK, 0, 0, '0, "R9");
    access(16'h501, BANK, 0, 1, LINES'(2), "R9");
  endtask

  task automatic t_stall;
    access(16'h501, BANK, 1, 1, LINES'(2), "R8");                 // K dirty
    active_cnt = 1;
    fill_valid = 1'b1; fill_addr = mk(16'h600, BANK);              // N -> line 1
    @(negedge clk);
    fill_valid = 1'b0;
    chk(active_lines == 2, "R8", 64'(active_lines), 2);
    chk(wb_valid == 1'b1 && wb_addr == mk(16'h501, BANK), "R8", 64'(wb_addr), 64'(mk(16'h501, BANK)));
    @(negedge clk);
    chk(active_lines == 1, "R8", 64'(active_lines), 1);
    chk(wb_valid == 1'b0, "R8", 64'(wb_valid), 0);
  endtask

  task automatic t_clamp_zero;
    active_cnt = 40;
    @(negedge clk);
    chk(active_lines == 32, "R6", 64'(active_lines), 32);
    active_cnt = 0;
    repeat (40) @(negedge clk);
    chk(active_lines == 0, "R7", 64'(active_lines), 0);
    fill(16'h700, BANK);
    chk(wb_valid == 1'b0, "R4", 64'(wb_valid), 0);
    active_cnt = 2;
    @(negedge clk);
    access(16'h700, BANK, 0, 0, '0, "R4");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    fill_valid = 1'b0; fill_addr = '0; active_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_wrap();
    t_bank();
    t_dirty();
    t_shrink();
    t_ptr_reset();
    t_stall();
    t_clamp_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule